// File: doc/BRIEF.md
# Single-Cycle 32-bit Subset Processor Core

This block is a 32-bit processor that finishes every instruction in one clock cycle. On each rising edge it commits the effects of the instruction that the program counter points at. Those effects are a register write, a data-memory write, and the next program counter value. Instructions are fetched from a small instruction store whose contents are computed inside the design. The core uses a 32-entry register file and a word-addressed data memory. It supports word load and store, immediate add, the register-register operations add, subtract, and, or and unsigned set-less-than, branch-if-equal, and an absolute jump.

The arithmetic unit takes a 3-bit operation code. Bit 2 of that code inverts the second operand and also supplies the adder carry-in. Unsigned less-than is read from the carry-out of that subtraction. The operation code comes from a two-level decode. An opcode decoder produces a 2-bit class. For register-register instructions, a function-field decoder then refines that class. Debug ports show the program counter and the data-memory write request, so a test environment can follow execution from outside the block.

Top module: `mcore_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter becomes 0. Execution restarts from word 0 after release.
- R2: Any instruction that is not a taken branch or a jump advances the program counter by 4.
- R3: Store (opcode 101011) writes register rt to the word at rs + sign-extended immediate, using address bits [31:2], and raises `dbg_mem_we` for that cycle only. Load (opcode 100011) writes that word into rt. No other opcode raises `dbg_mem_we`.
- R4: Immediate add (opcode 001000) writes rs plus the immediate, sign-extended from bit 15, into rt.
- R5: Opcode 000000 with function 100000, 100010, 100100 or 100101 writes rs+rt, rs-rt, rs AND rt or rs OR rt into the rd field's register.
- R6: Opcode 000000 with function 101011 writes 1 into rd when rs < rt as unsigned values, and 0 otherwise.
- R7: Branch-if-equal (opcode 000100) sets the next program counter to PC+4 + (sign-extended immediate << 2) when rs equals rt. Otherwise it sets it to PC+4.
- R8: Jump (opcode 000010) sets the next program counter to {PC+4 bits [31:28], instruction bits [25:0], 2'b00}.
- R9: Register 0 always reads as zero. Writes to register 0 have no effect.
- R10: An opcode outside the supported set writes no register and no memory, and advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_pc | output | 32 | Current program counter |
| dbg_mem_we | output | 1 | Data-memory write enable of the current instruction |
| dbg_mem_addr | output | 32 | Byte address computed by the current instruction |
| dbg_mem_wdata | output | 32 | Data presented for a store |

## Verification
Register contents can only be seen when a store copies them out to the debug ports. This makes the quiet cases the hardest to show: a write to register 0 and an unsupported opcode both leave nothing visible at the moment they execute. The built-in program follows each of these with a store of the register it could have changed. The bench's behavioural model checks the program counter and the store traffic on every cycle, so a wrong value shows up at the next store. Both branch outcomes are exercised, the skipped words after a taken branch and a jump would produce extra stores if they ran, and a mid-run reset checks that execution restarts from word 0.

// File: rtl/mcore_pkg.sv
`timescale 1ns/1ps
// mcore_pkg: shared opcodes, control word layout, ALU codes and the
// built-in program. Assumes 32-bit instruction words in the classic format.
package mcore_pkg;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_LOAD  = 6'b100011;
    localparam logic [5:0] OP_STORE = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_ADDI  = 6'b001000;
    localparam logic [5:0] OP_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD  = 6'b100000;
    localparam logic [5:0] FN_SUB  = 6'b100010;
    localparam logic [5:0] FN_AND  = 6'b100100;
    localparam logic [5:0] FN_OR   = 6'b100101;
    localparam logic [5:0] FN_SLTU = 6'b101011;

    typedef enum logic [2:0] {
        ALU_AND  = 3'b000,
        ALU_OR   = 3'b001,
        ALU_ADD  = 3'b010,
        ALU_ANDN = 3'b100,
        ALU_ORN  = 3'b101,
        ALU_SUB  = 3'b110,
        ALU_SLTU = 3'b111
    } alu_op_e;

    // Field order is fixed: the decoder table is written against it.
    typedef struct packed {
        logic       regwrite;
        logic       regdst;
        logic       alusrc;
        logic       branch;
        logic       memwrite;
        logic       memtoreg;
        logic       jump;
        logic [1:0] aluop;
    } ctrl_t;

    function automatic logic [31:0] mk_r(input logic [4:0] rs, rt, rd,
                                         input logic [5:0] fn);
        return {OP_RTYPE, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] mk_i(input logic [5:0] op,
                                         input logic [4:0] rs, rt,
                                         input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    // Built-in program: exercises every supported instruction.
    function automatic logic [31:0] prog_word(input int idx);
        case (idx)
            0:  return mk_i(OP_ADDI, 5'd0, 5'd1, 16'd5);
            1:  return mk_i(OP_ADDI, 5'd0, 5'd2, 16'hFFFD);
            2:  return mk_r(5'd1, 5'd2, 5'd3, FN_ADD);
            3:  return mk_r(5'd1, 5'd2, 5'd4, FN_SUB);
            4:  return mk_r(5'd1, 5'd2, 5'd5, FN_AND);
            5:  return mk_r(5'd1, 5'd2, 5'd6, FN_OR);
            6:  return mk_r(5'd1, 5'd2, 5'd7, FN_SLTU);
            7:  return mk_r(5'd2, 5'd1, 5'd8, FN_SLTU);
            8:  return mk_i(OP_STORE, 5'd0, 5'd3, 16'd0);
            9:  return mk_i(OP_STORE, 5'd0, 5'd4, 16'd4);
            10: return mk_i(OP_STORE, 5'd0, 5'd5, 16'd8);
            11: return mk_i(OP_STORE, 5'd0, 5'd6, 16'd12);
            12: return mk_i(OP_STORE, 5'd0, 5'd7, 16'd16);
            13: return mk_i(OP_STORE, 5'd0, 5'd8, 16'd20);
            14: return mk_i(OP_LOAD,  5'd0, 5'd9, 16'd4);
            15: return mk_i(OP_STORE, 5'd0, 5'd9, 16'd24);
            16: return mk_i(OP_ADDI,  5'd0, 5'd0, 16'd7);
            17: return mk_i(OP_STORE, 5'd0, 5'd0, 16'd28);
            18: return mk_i(6'b111111, 5'd0, 5'd1, 16'h1234);
            19: return mk_i(OP_STORE, 5'd0, 5'd1, 16'd32);
            20: return mk_i(OP_BEQ,   5'd1, 5'd2, 16'd5);
            21: return mk_i(OP_BEQ,   5'd1, 5'd1, 16'd2);
            22: return mk_i(OP_STORE, 5'd0, 5'd1, 16'd36);
            23: return mk_i(OP_STORE, 5'd0, 5'd1, 16'd36);
            24: return {OP_JUMP, 26'd27};
            25: return mk_i(OP_STORE, 5'd0, 5'd2, 16'd40);
            26: return mk_i(OP_STORE, 5'd0, 5'd2, 16'd40);
            27: return mk_i(OP_STORE, 5'd0, 5'd2, 16'd44);
            28: return mk_i(OP_BEQ,   5'd0, 5'd0, 16'hFFFF);
            default: return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/mcore_ctrl.sv
`timescale 1ns/1ps
// mcore_ctrl: two-level decode. The opcode picks the control word and a
// 2-bit ALU class. Class 2'b10 defers to the function field.
// Assumes a purely combinational use inside a single-cycle core.
module mcore_ctrl
    import mcore_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alu_op_e    alu_op
);

    // Opcode decoder: unknown opcodes produce an all-zero, inert word.
    always_comb begin
        case (op)
            OP_RTYPE: ctrl = 9'b110000010;
            OP_LOAD:  ctrl = 9'b101001000;
            OP_STORE: ctrl = 9'b001010000;
            OP_BEQ:   ctrl = 9'b000100001;
            OP_ADDI:  ctrl = 9'b101000000;
            OP_JUMP:  ctrl = 9'b000000100;
            default:  ctrl = 9'b000000000;
        endcase
    end

    // Function decoder: refines the ALU class into an ALU operation.
    always_comb begin
        case (ctrl.aluop)
            2'b00:   alu_op = ALU_ADD;
            2'b01:   alu_op = ALU_SUB;
            default: begin
                case (funct)
                    FN_SUB:  alu_op = ALU_SUB;
                    FN_AND:  alu_op = ALU_AND;
                    FN_OR:   alu_op = ALU_OR;
                    FN_SLTU: alu_op = ALU_SLTU;
                    default: alu_op = ALU_ADD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/mcore_alu.sv
`timescale 1ns/1ps
// mcore_alu: one adder shared by add, subtract and unsigned compare.
// Code bit 2 inverts B and supplies the carry-in. Bits [1:0] select the
// result. Assumes W >= 2.
module mcore_alu
    import mcore_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] result,
    output logic         zero
);

    logic [W-1:0] b_sel;
    logic [W:0]   sum;

    assign b_sel = op[2] ? ~b : b;
    assign sum   = {1'b0, a} + {1'b0, b_sel} + {{W{1'b0}}, op[2]};

    // Result select on the low code bits.
    always_comb begin
        case (op[1:0])
            2'b00:   result = a & b_sel;
            2'b01:   result = a | b_sel;
            2'b10:   result = sum[W-1:0];
            default: result = {{(W-1){1'b0}}, ~sum[W]};
        endcase
    end

    assign zero = (result == '0);

    // Unsigned compare must agree with a direct comparison.
    always_comb begin
        if (op == ALU_SLTU) begin
            p_sltu_matches_r6: assert (result == {{(W-1){1'b0}}, (a < b)});
        end
    end

endmodule

// File: rtl/mcore_regfile.sv
`timescale 1ns/1ps
// mcore_regfile: two combinational read ports and one write port on the
// rising edge. Entry 0 is hard-wired to zero. Reset clears all entries.
module mcore_regfile #(
    parameter int W     = 32,
    parameter int NREGS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREGS)-1:0] ra1,
    input  logic [$clog2(NREGS)-1:0] ra2,
    output logic [W-1:0]             rd1,
    output logic [W-1:0]             rd2,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] wa,
    input  logic [W-1:0]             wd
);

    logic [W-1:0] regs [NREGS];

    // Write port; writes aimed at entry 0 are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));

    p_zero_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ra1 == '0) |-> (rd1 == '0));

endmodule

// File: rtl/mcore_top.sv
`timescale 1ns/1ps
// mcore_top: single-cycle core. It holds the program counter, the
// computed instruction store and the data memory, and wires the decoder,
// ALU and register file together. Assumes a 32-bit word and word-aligned
// accesses.
module mcore_top
    import mcore_pkg::*;
#(
    parameter int IMEM_WORDS = 32,
    parameter int DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] dbg_pc,
    output logic        dbg_mem_we,
    output logic [31:0] dbg_mem_addr,
    output logic [31:0] dbg_mem_wdata
);

    localparam int W    = 32;
    localparam int IA_W = $clog2(IMEM_WORDS);
    localparam int DA_W = $clog2(DMEM_WORDS);

    logic [W-1:0] pc, pc_next, pc_plus4, br_target, jmp_target;
    logic [W-1:0] instr, imm_ext, rd1, rd2, alu_b, alu_res, ld_data, wb_data;
    logic [4:0]   wr_reg;
    ctrl_t        ctrl;
    alu_op_e      alu_op;
    logic         alu_zero, br_taken, known_op;
    logic [W-1:0] imem [IMEM_WORDS];
    logic [W-1:0] dmem [DMEM_WORDS];
    logic         unused_bits;

    // Instruction store built from the package program.
    for (genvar gi = 0; gi < IMEM_WORDS; gi++) begin : g_imem
        assign imem[gi] = prog_word(gi);
    end

    assign instr   = imem[pc[IA_W+1:2]];
    assign imm_ext = {{16{instr[15]}}, instr[15:0]};

    mcore_ctrl u_ctrl (
        .op     (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl),
        .alu_op (alu_op)
    );

    assign wr_reg = ctrl.regdst ? instr[15:11] : instr[20:16];

    mcore_regfile #(.W(W), .NREGS(32)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (instr[25:21]),
        .ra2   (instr[20:16]),
        .rd1   (rd1),
        .rd2   (rd2),
        .we    (ctrl.regwrite),
        .wa    (wr_reg),
        .wd    (wb_data)
    );

    assign alu_b = ctrl.alusrc ? imm_ext : rd2;

    mcore_alu #(.W(W)) u_alu (
        .a      (rd1),
        .b      (alu_b),
        .op     (alu_op),
        .result (alu_res),
        .zero   (alu_zero)
    );

    // Data memory write port.
    always_ff @(posedge clk) begin
        if (ctrl.memwrite) dmem[alu_res[DA_W+1:2]] <= rd2;
    end

    assign ld_data = dmem[alu_res[DA_W+1:2]];
    assign wb_data = ctrl.memtoreg ? ld_data : alu_res;

    assign pc_plus4   = pc + 32'd4;
    assign br_target  = pc_plus4 + (imm_ext << 2);
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign br_taken   = ctrl.branch && alu_zero;

    // Next-PC priority: jump, then taken branch, then sequential.
    always_comb begin
        if (ctrl.jump)     pc_next = jmp_target;
        else if (br_taken) pc_next = br_target;
        else               pc_next = pc_plus4;
    end

    // Program counter register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    assign dbg_pc        = pc;
    assign dbg_mem_we    = ctrl.memwrite;
    assign dbg_mem_addr  = alu_res;
    assign dbg_mem_wdata = rd2;

    assign unused_bits = ^{pc[1:0], pc[W-1:IA_W+2], alu_res[1:0],
                           alu_res[W-1:DA_W+2], instr[10:6]};

    assign known_op = (instr[31:26] == OP_RTYPE) || (instr[31:26] == OP_LOAD)
                   || (instr[31:26] == OP_STORE) || (instr[31:26] == OP_BEQ)
                   || (instr[31:26] == OP_ADDI)  || (instr[31:26] == OP_JUMP);

    p_reset_pc_r1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.jump && !br_taken) |=> (pc == $past(pc) + 32'd4));

    p_branch_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (pc == $past(pc) + 32'd4 + ($past(imm_ext) << 2)));

    p_jump_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.jump |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}));

    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |-> (!ctrl.regwrite && !ctrl.memwrite && !ctrl.jump && !ctrl.branch));

    p_store_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mem_we |-> (instr[31:26] == OP_STORE));

endmodule

// File: tb/mcore_top_bench.sv
`timescale 1ns/1ps
// Bench: behavioural instruction-level model, compared on every cycle.
module mcore_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dbg_pc, dbg_mem_addr, dbg_mem_wdata;
    logic        dbg_mem_we;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    mcore_top u_mcore_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .dbg_pc        (dbg_pc),
        .dbg_mem_we    (dbg_mem_we),
        .dbg_mem_addr  (dbg_mem_addr),
        .dbg_mem_wdata (dbg_mem_wdata)
    );

    // Model state.
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [64];
    logic [31:0] m_pc;
    string       pc_tag;

    function automatic logic [31:0] ri(int op, int rs, int rt, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] rr(int rs, int rt, int rd, int fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
    endfunction

    // Test program, written independently of the design.
    function automatic logic [31:0] prog(int i);
        case (i)
            0:  return ri(8, 0, 1, 5);
            1:  return ri(8, 0, 2, -3);
            2:  return rr(1, 2, 3, 32);
            3:  return rr(1, 2, 4, 34);
            4:  return rr(1, 2, 5, 36);
            5:  return rr(1, 2, 6, 37);
            6:  return rr(1, 2, 7, 43);
            7:  return rr(2, 1, 8, 43);
            8:  return ri(43, 0, 3, 0);
            9:  return ri(43, 0, 4, 4);
            10: return ri(43, 0, 5, 8);
            11: return ri(43, 0, 6, 12);
            12: return ri(43, 0, 7, 16);
            13: return ri(43, 0, 8, 20);
            14: return ri(35, 0, 9, 4);
            15: return ri(43, 0, 9, 24);
            16: return ri(8, 0, 0, 7);
            17: return ri(43, 0, 0, 28);
            18: return ri(63, 0, 1, 'h1234);
            19: return ri(43, 0, 1, 32);
            20: return ri(4, 1, 2, 5);
            21: return ri(4, 1, 1, 2);
            22: return ri(43, 0, 1, 36);
            23: return ri(43, 0, 1, 36);
            24: return {6'd2, 26'd27};
            25: return ri(43, 0, 2, 40);
            26: return ri(43, 0, 2, 40);
            27: return ri(43, 0, 2, 44);
            28: return ri(4, 0, 0, -1);
            default: return 32'd0;
        endcase
    endfunction

    // Requirement that the stored data of each word depends on.
    function automatic string data_tag(int i);
        case (i)
            8, 9, 10, 11: return "R5";
            12, 13:       return "R6";
            17:           return "R9";
            19:           return "R10";
            27:           return "R4";
            default:      return "R3";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
        m_pc = 32'd0;
        pc_tag = "R1";
    endtask

    // Compare the current outputs, then advance the model one instruction.
    task automatic compare_and_step();
        logic [31:0] ins, sx, va, vb, nxt, res;
        int op, rs, rt, rd, fn, idx;
        bit wr;
        int dst;
        idx = int'(m_pc >> 2);
        ins = (idx < 32) ? prog(idx) : 32'd0;
        op = int'(ins[31:26]); rs = int'(ins[25:21]); rt = int'(ins[20:16]);
        rd = int'(ins[15:11]); fn = int'(ins[5:0]);
        sx = {{16{ins[15]}}, ins[15:0]};
        va = m_reg[rs]; vb = m_reg[rt];
        chk(pc_tag, "pc", dbg_pc, m_pc);
        chk((op == 63) ? "R10" : "R3", "mem_we", {31'd0, dbg_mem_we}, {31'd0, op == 43});
        if (op == 43) begin
            chk("R3", "store addr", dbg_mem_addr, va + sx);
            chk(data_tag(idx), "store data", dbg_mem_wdata, vb);
        end
        nxt = m_pc + 4; pc_tag = "R2"; wr = 0; dst = 0; res = 0;
        case (op)
            0: begin
                wr = 1; dst = rd;
                case (fn)
                    34: res = va - vb;
                    36: res = va & vb;
                    37: res = va | vb;
                    43: res = (va < vb) ? 32'd1 : 32'd0;
                    default: res = va + vb;
                endcase
            end
            35: begin wr = 1; dst = rt; res = m_mem[(va + sx) >> 2]; end
            43: m_mem[(va + sx) >> 2] = vb;
            8:  begin wr = 1; dst = rt; res = va + sx; end
            4:  begin
                pc_tag = "R7";
                if (va == vb) nxt = m_pc + 4 + (sx << 2);
            end
            2:  begin
                pc_tag = "R8";
                nxt = {nxt[31:28], ins[25:0], 2'b00};
            end
            default: pc_tag = "R10";
        endcase
        if (wr && dst != 0) m_reg[dst] = res;
        m_pc = nxt;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_mem[i] = 32'd0;
        model_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "pc after reset", dbg_pc, 32'd0);
        rst_n = 1'b1;
        for (int c = 0; c < 40; c++) begin
            compare_and_step();
            @(negedge clk);
        end
        // Mid-run reset: execution restarts from word 0.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "pc after mid-run reset", dbg_pc, 32'd0);
        model_reset();
        rst_n = 1'b1;
        for (int c = 0; c < 20; c++) begin
            compare_and_step();
            @(negedge clk);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual=%0d expected=%0d", 20000, 80);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule